// File: doc/BRIEF.md
# 1-Wire ROM Command Layer (Slave)

This block is the network layer of a 1-Wire slave. It sits above a bit-level PHY that detects reset pulses, decodes master write slots into received bits and serves read slots from a bit the layer offers. After every reset/presence cycle the layer collects an 8-bit ROM command and runs it against a 64-bit identity fixed by a parameter. Depending on the command, it reads out the identity, compares it, or takes part in the binary search. At the end it either hands the bus to the function layer or goes quiet until the next reset.

Two flags persist across bus resets. The resume flag records that this slave was the last one singled out by address. The overdrive flag selects the fast timing in the PHY and is driven out as `odMode`. The identity is laid out with the family byte in bits 7:0, the 48-bit serial in bits 55:8 and the check byte in bits 63:56. All bytes and the identity move over the wire least significant bit first.

Top module: `owrom_layer`

## Requirements
- R1: After power-on reset `funcGrant`, `txReq` and `odMode` are 0, and received bits are ignored until the first `busRst` pulse.
- R2: After each `busRst` pulse the block takes 8 received bits as a command byte, LSB first. The codes are 33h read, 55h match, F0h search, CCh skip, A5h resume, 3Ch overdrive-skip and 69h overdrive-match.
- R3: Read (33h) offers the 64 identity bits LSB first, one per `txDone`: family byte, then serial, then check byte. After the last bit it raises `funcGrant`.
- R4: Match (55h) compares 64 received bits with the identity. A full match raises `funcGrant` and sets the resume flag. Any mismatch leaves `funcGrant` and `txReq` low until the next reset.
- R5: Search (F0h) runs three slots per identity bit, LSB first: it offers the true bit, then its complement, then reads the master's bit. On a mismatch it stops offering bits until reset. After 64 bits it raises `funcGrant` and sets the resume flag.
- R6: Skip (CCh) raises `funcGrant` at once and never offers a bit.
- R7: Resume (A5h) raises `funcGrant` only when the resume flag is set; otherwise it waits for reset. The flag survives bus resets. Read, match, search, skip and both overdrive commands clear it; resume itself leaves it unchanged.
- R8: Overdrive-skip (3Ch) sets `odMode` to 1 and raises `funcGrant`.
- R9: Overdrive-match (69h) sets `odMode` to 1 right after the command byte. A full match raises `funcGrant` with `odMode` still 1 and sets the resume flag. A mismatch returns `odMode` to 0.
- R10: A `busRst` pulse with `busRstLong` = 1 clears `odMode`. With `busRstLong` = 0 it leaves `odMode` unchanged.
- R11: Any other command code leaves `funcGrant` and `txReq` low until the next reset.
- R12: A `busRst` pulse in any state abandons the running command, drops `funcGrant` and `txReq`, and starts a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low |
| busRst | input | 1 | One-cycle pulse from PHY: reset/presence cycle done |
| busRstLong | input | 1 | Qualifies `busRst`: reset low time was of the long (standard) kind |
| rxValid | input | 1 | One-cycle pulse: a master write slot carried `rxBit` |
| rxBit | input | 1 | Received bit value |
| txDone | input | 1 | One-cycle pulse: a read slot consumed `txBit` |
| txReq | output | 1 | Layer has a bit to put on the next read slot |
| txBit | output | 1 | Bit offered for the read slot |
| funcGrant | output | 1 | Function layer may take the bus |
| odMode | output | 1 | Overdrive timing selected |

## Verification
The bench targets the flag corner cases. These include resume after a match across both short and long resets, resume refused after a skip or a failed match, and `odMode` held over a short reset but dropped by a long one or by a failed overdrive match. A design that cleared the resume flag on reset, or cleared it at the start of resume, would refuse a legitimate resume. Search is driven both to completion and into a mid-stream drop-out. A slave that kept offering bits after losing would corrupt the wired-AND result. A read is cut off by a reset, and garbage command codes are sent, to show that the block goes silent rather than driving the line or granting access.

// File: rtl/owrom_pkg.sv
package owrom_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_READ     = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH    = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SEARCH   = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_SKIP     = 8'hCC;
  localparam logic [CMD_W-1:0] CMD_RESUME   = 8'hA5;
  localparam logic [CMD_W-1:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [CMD_W-1:0] CMD_OD_MATCH = 8'h69;

  typedef enum logic [3:0] {
    ST_IDLE,      // silent until next bus reset
    ST_CMD,       // collecting command byte
    ST_READ,      // sending identity
    ST_MATCH,     // comparing identity
    ST_ODMATCH,   // comparing identity, overdrive variant
    ST_SRCH_T,    // search: offer true bit
    ST_SRCH_C,    // search: offer complement
    ST_SRCH_R,    // search: read master choice
    ST_GRANT      // function layer owns the bus
  } romState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic cmdShift;
    logic rcSet;
    logic rcClr;
    logic odSet;
    logic odClr;
  } dpStrobe_t;
endpackage

// File: rtl/owrom_dp.sv
module owrom_dp
  import owrom_pkg::*;
#(
  parameter int ID_W = 64,
  parameter logic [ID_W-1:0] ROM_ID = '0,
  localparam int CNT_W = $clog2(ID_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic             rxBit,
  output logic [CNT_W-1:0] bitCnt,
  output logic [CMD_W-1:0] cmdNext,
  output logic             idBit,
  output logic             rcFlag,
  output logic             odFlag
);
  logic [CMD_W-2:0] cmdReg;

  // bytes arrive LSB first: shift in at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdReg <= '0;
    else if (strb.cmdShift) cmdReg <= {rxBit, cmdReg[CMD_W-2:1]};
  end
  assign cmdNext = {rxBit, cmdReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (strb.cntClr) bitCnt <= '0;
    else if (strb.cntInc) bitCnt <= bitCnt + 1'b1;
  end

  assign idBit = ROM_ID[bitCnt];

  // resume flag: only power-on clears it apart from command rules
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rcFlag <= 1'b0;
    else if (strb.rcSet) rcFlag <= 1'b1;
    else if (strb.rcClr) rcFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) odFlag <= 1'b0;
    else if (strb.odClr) odFlag <= 1'b0;
    else if (strb.odSet) odFlag <= 1'b1;
  end

  // control must never ask to set and clear the resume flag together
  assert_rc_strobe_excl_R7 : assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rcSet && strb.rcClr));
  // counter clear and advance are exclusive requests
  assert_cnt_strobe_excl_R4 : assert property (@(posedge clk) disable iff (!rstN)
    !(strb.cntClr && strb.cntInc));
endmodule

// File: rtl/owrom_ctrl.sv
module owrom_ctrl
  import owrom_pkg::*;
#(
  parameter int ID_W = 64,
  localparam int CNT_W = $clog2(ID_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busRst,
  input  logic             busRstLong,
  input  logic             rxValid,
  input  logic             rxBit,
  input  logic             txDone,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic [CMD_W-1:0] cmdNext,
  input  logic             idBit,
  input  logic             rcFlag,
  output dpStrobe_t        strb,
  output logic             txReq,
  output logic             txBit,
  output logic             funcGrant
);
  romState_t state, nxt;
  logic lastId, lastCmd;

  assign lastId  = (bitCnt == CNT_W'(ID_W - 1));
  assign lastCmd = (bitCnt == CNT_W'(CMD_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nxt;
  end

  always_comb begin
    nxt  = state;
    strb = '0;
    if (busRst) begin
      nxt = ST_CMD;
      strb.cntClr = 1'b1;
      strb.odClr  = busRstLong;
    end else begin
      unique case (state)
        ST_CMD: if (rxValid) begin
          strb.cmdShift = 1'b1;
          if (!lastCmd) strb.cntInc = 1'b1;
          else begin
            strb.cntClr = 1'b1;
            case (cmdNext)
              CMD_READ:     begin strb.rcClr = 1'b1; nxt = ST_READ; end
              CMD_MATCH:    begin strb.rcClr = 1'b1; nxt = ST_MATCH; end
              CMD_SEARCH:   begin strb.rcClr = 1'b1; nxt = ST_SRCH_T; end
              CMD_SKIP:     begin strb.rcClr = 1'b1; nxt = ST_GRANT; end
              CMD_RESUME:   nxt = rcFlag ? ST_GRANT : ST_IDLE;
              CMD_OD_SKIP:  begin strb.rcClr = 1'b1; strb.odSet = 1'b1; nxt = ST_GRANT; end
              CMD_OD_MATCH: begin strb.rcClr = 1'b1; strb.odSet = 1'b1; nxt = ST_ODMATCH; end
              default:      nxt = ST_IDLE;
            endcase
          end
        end
        ST_READ: if (txDone) begin
          if (lastId) nxt = ST_GRANT;
          else strb.cntInc = 1'b1;
        end
        ST_MATCH, ST_ODMATCH: if (rxValid) begin
          if (rxBit != idBit) begin
            nxt = ST_IDLE;
            strb.odClr = (state == ST_ODMATCH);
          end else if (lastId) begin
            strb.rcSet = 1'b1;
            nxt = ST_GRANT;
          end else strb.cntInc = 1'b1;
        end
        ST_SRCH_T: if (txDone) nxt = ST_SRCH_C;
        ST_SRCH_C: if (txDone) nxt = ST_SRCH_R;
        ST_SRCH_R: if (rxValid) begin
          if (rxBit != idBit) nxt = ST_IDLE;
          else if (lastId) begin
            strb.rcSet = 1'b1;
            nxt = ST_GRANT;
          end else begin
            strb.cntInc = 1'b1;
            nxt = ST_SRCH_T;
          end
        end
        default: ;
      endcase
    end
  end

  assign txReq     = (state == ST_READ) || (state == ST_SRCH_T) || (state == ST_SRCH_C);
  assign txBit     = (state == ST_SRCH_C) ? ~idBit : idBit;
  assign funcGrant = (state == ST_GRANT);

  // access is only ever granted right after a bit exchange on the bus
  assert_grant_follows_bit_R2 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(funcGrant) |-> $past(rxValid || txDone));
  // any bus reset stops the current command on the next cycle
  assert_reset_aborts_R12 : assert property (@(posedge clk) disable iff (!rstN)
    busRst |=> (!funcGrant && !txReq));
  // granted slave leaves the read slots alone
  assert_no_tx_in_grant_R6 : assert property (@(posedge clk) disable iff (!rstN)
    !(txReq && funcGrant));
endmodule

// File: rtl/owrom_layer.sv
module owrom_layer
  import owrom_pkg::*;
#(
  parameter int ID_W = 64,
  parameter logic [ID_W-1:0] ROM_ID = 64'hC41F2E3D4C5B6A28
) (
  input  logic clk,
  input  logic rstN,
  input  logic busRst,
  input  logic busRstLong,
  input  logic rxValid,
  input  logic rxBit,
  input  logic txDone,
  output logic txReq,
  output logic txBit,
  output logic funcGrant,
  output logic odMode
);
  localparam int CNT_W = $clog2(ID_W);

  dpStrobe_t        strb;
  logic [CNT_W-1:0] bitCnt;
  logic [CMD_W-1:0] cmdNext;
  logic             idBit, rcFlag;

  owrom_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busRst(busRst), .busRstLong(busRstLong),
    .rxValid(rxValid), .rxBit(rxBit), .txDone(txDone),
    .bitCnt(bitCnt), .cmdNext(cmdNext), .idBit(idBit), .rcFlag(rcFlag),
    .strb(strb), .txReq(txReq), .txBit(txBit), .funcGrant(funcGrant)
  );

  owrom_dp #(.ID_W(ID_W), .ROM_ID(ROM_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxBit(rxBit),
    .bitCnt(bitCnt), .cmdNext(cmdNext), .idBit(idBit),
    .rcFlag(rcFlag), .odFlag(odMode)
  );

  // long reset always returns to standard timing
  assert_long_reset_clears_od_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (busRst && busRstLong) |=> !odMode);
  // overdrive can only come on after a received command bit
  assert_od_rise_on_rx_R8 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(odMode) |-> $past(rxValid));
endmodule

// File: tb/test_owrom_layer.sv
module test_owrom_layer;
  localparam logic [63:0] TB_ID = 64'hC41F2E3D4C5B6A28;

  logic clk = 1'b0, rstN = 1'b0;
  logic busRst = 0, busRstLong = 0, rxValid = 0, rxBit = 0, txDone = 0;
  logic txReq, txBit, funcGrant, odMode;
  int checkCnt = 0, failCnt = 0;

  always #10 clk = ~clk;

  owrom_layer #(.ID_W(64), .ROM_ID(TB_ID)) i_owrom_layer (
    .clk(clk), .rstN(rstN), .busRst(busRst), .busRstLong(busRstLong),
    .rxValid(rxValid), .rxBit(rxBit), .txDone(txDone),
    .txReq(txReq), .txBit(txBit), .funcGrant(funcGrant), .odMode(odMode)
  );

  // {code, grant, od, txReq} after long reset + command byte
  localparam logic [10:0] VEC [9] = '{
    {8'hCC, 3'b100}, {8'h3C, 3'b110}, {8'h33, 3'b001}, {8'hF0, 3'b001},
    {8'h55, 3'b000}, {8'h69, 3'b010}, {8'hA5, 3'b000}, {8'h00, 3'b000},
    {8'hFF, 3'b000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busReset(input logic isLong);
    @(negedge clk); busRst = 1; busRstLong = isLong;
    @(negedge clk); busRst = 0; busRstLong = 0;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); rxValid = 1; rxBit = b;
    @(negedge clk); rxValid = 0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  task automatic sendId(input int flipIdx);
    for (int i = 0; i < 64; i++) sendBit(TB_ID[i] ^ (i == flipIdx));
  endtask

  task automatic readBit(output logic got, output logic present);
    @(negedge clk); present = txReq; got = txBit; txDone = 1;
    @(negedge clk); txDone = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin : main
    logic b, p, c, pc;
    logic [63:0] rd;
    logic allPresent;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state and bits ignored before first bus reset
    chk("R1 grant", funcGrant, 0);
    chk("R1 txReq", txReq, 0);
    chk("R1 odMode", odMode, 0);
    sendByte(8'hCC);
    chk("R1 ignored before reset", {funcGrant, txReq}, 0);

    // R2 table: R6 R8 R11 code decode
    for (int k = 0; k < 9; k++) begin
      busReset(1);
      sendByte(VEC[k][10:3]);
      chk($sformatf("R2 table %h grant", VEC[k][10:3]), funcGrant, VEC[k][2]);
      chk($sformatf("R2 table %h od", VEC[k][10:3]), odMode, VEC[k][1]);
      chk($sformatf("R2 table %h txReq", VEC[k][10:3]), txReq, VEC[k][0]);
    end

    // R11: unknown code stays silent over further slots
    busReset(1); sendByte(8'h12);
    sendByte(8'hCC);
    chk("R11 silent after unknown", {funcGrant, txReq}, 0);

    // R3: read identity
    busReset(1); sendByte(8'h33);
    allPresent = 1;
    for (int i = 0; i < 64; i++) begin readBit(b, p); rd[i] = b; allPresent &= p; end
    chk("R3 bits offered", allPresent, 1);
    chk("R3 family byte", rd[7:0], TB_ID[7:0]);
    chk("R3 full identity", rd, TB_ID);
    chk("R3 grant after read", {funcGrant, txReq}, 2'b10);

    // R12: reset mid-read
    busReset(1); sendByte(8'h33);
    for (int i = 0; i < 5; i++) readBit(b, p);
    busReset(0);
    chk("R12 abort", {funcGrant, txReq}, 0);
    sendByte(8'hCC);
    chk("R12 new command", funcGrant, 1);

    // R4: match then R7 resume across short and long resets
    busReset(1); sendByte(8'h55); sendId(-1);
    chk("R4 match grant", funcGrant, 1);
    busReset(0); sendByte(8'hA5);
    chk("R7 resume after match", funcGrant, 1);
    busReset(1); sendByte(8'hA5);
    chk("R7 resume repeated", funcGrant, 1);
    busReset(1); sendByte(8'h55); sendId(10);
    chk("R4 mismatch", {funcGrant, txReq}, 0);
    busReset(1); sendByte(8'hA5);
    chk("R7 resume refused after failed match", funcGrant, 0);

    // R5: full search
    busReset(1); sendByte(8'hF0);
    allPresent = 1;
    for (int i = 0; i < 64; i++) begin
      readBit(b, p); readBit(c, pc);
      allPresent &= p & pc & (b == TB_ID[i]) & (c == ~TB_ID[i]);
      sendBit(TB_ID[i]);
    end
    chk("R5 search true/complement bits", allPresent, 1);
    chk("R5 search grant", funcGrant, 1);
    busReset(1); sendByte(8'hA5);
    chk("R7 resume after search", funcGrant, 1);
    // R6: skip clears resume
    busReset(1); sendByte(8'hCC);
    busReset(1); sendByte(8'hA5);
    chk("R6 skip clears resume", funcGrant, 0);

    // R5: drop-out on bit 1
    busReset(1); sendByte(8'hF0);
    readBit(b, p); readBit(c, pc); sendBit(TB_ID[0]);
    readBit(b, p); readBit(c, pc); sendBit(~TB_ID[1]);
    repeat (3) @(negedge clk);
    chk("R5 drop-out silent", {funcGrant, txReq}, 0);

    // R9: overdrive match, then R10 resets
    busReset(1); sendByte(8'h69);
    chk("R9 od set by command", odMode, 1);
    sendId(-1);
    chk("R9 grant with od", {funcGrant, odMode}, 2'b11);
    busReset(0);
    chk("R10 short reset keeps od", odMode, 1);
    sendByte(8'hA5);
    chk("R7 resume after overdrive match", funcGrant, 1);
    busReset(1);
    chk("R10 long reset clears od", odMode, 0);
    sendByte(8'h69); sendId(63);
    chk("R9 mismatch clears od", {funcGrant, odMode}, 0);

    // R8: overdrive skip survives short reset
    busReset(1); sendByte(8'h3C);
    busReset(0);
    chk("R8 od held over short reset", odMode, 1);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule